// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block keeps the 13-bit fetch address for a small microcontroller core whose instructions are 14 bits wide, along with an eight-entry stack of return addresses. Each instruction cycle it either holds, steps, jumps to a subroutine, returns from one, or loads a fixed vector. Decoded strobes from the instruction decoder drive it, and its output feeds the program memory address port directly.

A subroutine jump forms its target from two sources. The low eleven bits come from the instruction's immediate field. The top two bits come from bits 4 and 3 of a separate five-bit upper-address latch. The address after the calling instruction is saved on the stack. A jump, a return or a vector load is followed by one dead cycle, during which the freshly fetched word is discarded. The `flush` output marks that cycle, and the decode strobes are ignored while it is high. The stack is circular: once it is full, a further push overwrites the oldest entry, and no flag reports this.

Top module: `pc_callstack`

## Requirements
- R1: A synchronous active-high `rst` forces `fetch_addr` to 0, `flush` to 0 and the stack pointer to the empty position. This holds even if a jump's dead cycle was pending.
- R2: In a cycle with `adv_en` high and no other action taken, `fetch_addr` rises by one at the next edge and wraps from 13'h1FFF to 0. With no strobe, it holds.
- R3: A call (`call_req` high, `flush` low) sets `fetch_addr` to {`hi_latch[4:3]`, `call_imm[10:0]`}. Bits 2..0 of `hi_latch` have no effect.
- R4: A call pushes the calling address plus one, modulo 2^13, so the matching return resumes at the instruction after the call.
- R5: A call, return or vector load raises `flush` for exactly the following cycle. In that cycle `call_req` and `ret_req` are ignored, and `fetch_addr` steps by one if `adv_en` is high or holds otherwise.
- R6: A return (`ret_req` high, `flush` low, no call) loads all 13 bits of `fetch_addr` from the newest stack entry and removes that entry. Nested calls return in last-in-first-out order.
- R7: The stack holds 8 entries. The ninth push without a pop overwrites the oldest slot, so after nine pushes the ninth pop yields the ninth pushed value again.
- R8: If several strobes arrive in the same cycle, a call beats a return and a return beats an advance. The losing return leaves the stack unchanged.
- R9: `vec_load` has top priority, even in a dead cycle. It loads `fetch_addr` with the parameter VEC_ADDR (default 13'h0004), raises `flush`, and neither pushes nor pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Sequential-advance strobe |
| call_req | input | 1 | Decoded subroutine-call strobe |
| call_imm | input | 11 | Immediate target from the call instruction |
| hi_latch | input | 5 | Upper-address latch; bits 4:3 supply target bits 12:11 |
| ret_req | input | 1 | Decoded return strobe |
| vec_load | input | 1 | Vector-load stub strobe |
| fetch_addr | output | 13 | Current fetch address |
| flush | output | 1 | High during the dead cycle after a control transfer |

## Verification
The bench drives calls, returns and advances together in one cycle. It checks which target is loaded. It then returns again to show that the losing return never popped. Strobes are also driven during the dead cycle, including a vector load, to separate flush suppression from the vector's top priority. Each case is judged from the next edge's `fetch_addr` and `flush`, and from the addresses that later returns yield.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_W   = 13;
    localparam int IMM_W  = 11;
    localparam int LAT_W  = 5;
    localparam int HI_W   = PC_W - IMM_W;
    localparam int LAT_LO = IMM_W - 8;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_STEP,
        SEL_CALL,
        SEL_RET,
        SEL_VEC
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic push;
        logic pop;
        logic dead_next;
    } ctl_t;

    function automatic pc_t call_target(logic [IMM_W-1:0] imm, logic [LAT_W-1:0] lat);
        return {lat[LAT_LO +: HI_W], imm};
    endfunction

    function automatic pc_t pc_inc(pc_t p);
        return p + pc_t'(1);
    endfunction
endpackage

// File: rtl/pcs_sel.sv
module pcs_sel
    import pcs_pkg::*;
(
    input  logic in_dead,
    input  logic adv_en,
    input  logic call_req,
    input  logic ret_req,
    input  logic vec_load,
    output ctl_t ctl
);
    always_comb begin
        ctl = '{sel: SEL_HOLD, push: 1'b0, pop: 1'b0, dead_next: 1'b0};
        if (vec_load) begin
            ctl.sel       = SEL_VEC;
            ctl.dead_next = 1'b1;
        end else if (in_dead) begin
            ctl.sel = adv_en ? SEL_STEP : SEL_HOLD;
        end else if (call_req) begin
            ctl.sel       = SEL_CALL;
            ctl.push      = 1'b1;
            ctl.dead_next = 1'b1;
        end else if (ret_req) begin
            ctl.sel       = SEL_RET;
            ctl.pop       = 1'b1;
            ctl.dead_next = 1'b1;
        end else if (adv_en) begin
            ctl.sel = SEL_STEP;
        end
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
    import pcs_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_val,
    output pc_t  top_val
);
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pc_t             slots [DEPTH];
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;

    assign sp_dec  = sp_q - SP_W'(1);
    assign top_val = slots[sp_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push) begin
            slots[sp_q] <= push_val;
            sp_q        <= sp_q + SP_W'(1);
        end else if (pop) begin
            sp_q <= sp_dec;
        end
    end

    p_push_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        push |=> sp_q == SP_W'($past(sp_q) + 1'b1));

    p_pop_ptr_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> sp_q == SP_W'($past(sp_q) - 1'b1));

    p_hold_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (!pop && !push) |=> $stable(sp_q));
endmodule

// File: rtl/pc_callstack.sv
module pc_callstack
    import pcs_pkg::*;
#(
    parameter int  DEPTH    = 8,
    parameter pc_t VEC_ADDR = 13'h0004
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic             call_req,
    input  logic [IMM_W-1:0] call_imm,
    input  logic [LAT_W-1:0] hi_latch,
    input  logic             ret_req,
    input  logic             vec_load,
    output logic [PC_W-1:0]  fetch_addr,
    output logic             flush
);
    pc_t  pc_q, pc_nxt, stk_top;
    logic dead_q;
    ctl_t ctl;

    pcs_sel u_sel (
        .in_dead  (dead_q),
        .adv_en   (adv_en),
        .call_req (call_req),
        .ret_req  (ret_req),
        .vec_load (vec_load),
        .ctl      (ctl)
    );

    pcs_ret_stack #(.DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .push_val (pc_inc(pc_q)),
        .top_val  (stk_top)
    );

    always_comb begin
        unique case (ctl.sel)
            SEL_STEP: pc_nxt = pc_inc(pc_q);
            SEL_CALL: pc_nxt = call_target(call_imm, hi_latch);
            SEL_RET:  pc_nxt = stk_top;
            SEL_VEC:  pc_nxt = VEC_ADDR;
            default:  pc_nxt = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            dead_q <= 1'b0;
        end else begin
            pc_q   <= pc_nxt;
            dead_q <= ctl.dead_next;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = dead_q;

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !vec_load && !call_req && !ret_req)
        |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

    p_call_target_r3: assert property (@(posedge clk) disable iff (rst)
        (call_req && !flush && !vec_load)
        |=> fetch_addr == {$past(hi_latch[LAT_LO +: HI_W]), $past(call_imm)});

    p_call_dead_r5: assert property (@(posedge clk) disable iff (rst)
        (call_req && !flush && !vec_load) |=> flush);

    p_dead_single_r5: assert property (@(posedge clk) disable iff (rst)
        (flush && !vec_load) |=> !flush);

    p_ret_dead_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && !flush && !vec_load) |=> flush);

    p_vector_r9: assert property (@(posedge clk) disable iff (rst)
        vec_load |=> (fetch_addr == VEC_ADDR) && flush);
endmodule

// File: tb/pc_callstack_test.sv
module pc_callstack_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0, call_req = 1'b0, ret_req = 1'b0, vec_load = 1'b0;
    logic [10:0] call_imm = '0;
    logic [4:0]  hi_latch = '0;
    logic [12:0] fetch_addr;
    logic        flush;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pc_callstack uut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .call_req(call_req),
        .call_imm(call_imm), .hi_latch(hi_latch), .ret_req(ret_req),
        .vec_load(vec_load), .fetch_addr(fetch_addr), .flush(flush)
    );

    typedef struct packed {
        logic        a, c, r, v;
        logic [10:0] imm;
        logic [4:0]  lat;
        logic [12:0] pc;
        logic        fl;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 17;
    localparam row_t TBL [NROWS] = '{
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0001, 1'b0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0002, 1'b0, 4'd2},
        '{1'b0,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0002, 1'b0, 4'd2},
        '{1'b0,1'b1,1'b0,1'b0, 11'h123, 5'h08, 13'h0923, 1'b1, 4'd3},
        '{1'b1,1'b1,1'b0,1'b0, 11'h7FF, 5'h18, 13'h0924, 1'b0, 4'd5},
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0925, 1'b0, 4'd2},
        '{1'b0,1'b1,1'b0,1'b0, 11'h010, 5'h17, 13'h1010, 1'b1, 4'd3},
        '{1'b0,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h1010, 1'b0, 4'd5},
        '{1'b0,1'b0,1'b1,1'b0, 11'h000, 5'h00, 13'h0926, 1'b1, 4'd6},
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0927, 1'b0, 4'd5},
        '{1'b0,1'b0,1'b1,1'b0, 11'h000, 5'h00, 13'h0003, 1'b1, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0004, 1'b0, 4'd5},
        '{1'b1,1'b1,1'b1,1'b0, 11'h055, 5'h00, 13'h0055, 1'b1, 4'd8},
        '{1'b1,1'b0,1'b1,1'b0, 11'h000, 5'h00, 13'h0056, 1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b0, 11'h000, 5'h00, 13'h0005, 1'b1, 4'd8},
        '{1'b1,1'b1,1'b0,1'b1, 11'h000, 5'h00, 13'h0004, 1'b1, 4'd9},
        '{1'b1,1'b0,1'b0,1'b0, 11'h000, 5'h00, 13'h0005, 1'b0, 4'd9}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic step(input logic a, c, r, v, input logic [10:0] imm, input logic [4:0] lat);
        @(negedge clk);
        adv_en = a; call_req = c; ret_req = r; vec_load = v;
        call_imm = imm; hi_latch = lat;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [12:0] exp_pc, input logic exp_fl);
        n_checks++;
        if (fetch_addr !== exp_pc || flush !== exp_fl) begin
            n_errors++;
            $display("FAIL %s: fetch_addr=%h flush=%b expected fetch_addr=%h flush=%b",
                     tag, fetch_addr, flush, exp_pc, exp_fl);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        adv_en = 0; call_req = 0; ret_req = 0; vec_load = 0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        // R1: state after reset
        @(posedge clk);
        #1;
        check("R1 reset", 13'h0000, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].a, TBL[i].c, TBL[i].r, TBL[i].v, TBL[i].imm, TBL[i].lat);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].pc, TBL[i].fl);
        end

        // R1: reset mid-run, and reset cancelling a pending dead cycle
        do_reset();
        check("R1 reset mid-run", 13'h0000, 1'b0);
        step(1, 1, 0, 0, 11'h3AA, 5'h00);
        @(negedge clk);
        rst = 1'b1;
        adv_en = 0; call_req = 0;
        @(posedge clk);
        #1;
        check("R1 reset clears flush", 13'h0000, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R2 wrap and R4 push wrap
        step(0, 1, 0, 0, 11'h7FF, 5'h18);
        check("R3 top target", 13'h1FFF, 1'b1);
        step(0, 0, 0, 0, 11'h000, 5'h00);
        check("R5 dead hold", 13'h1FFF, 1'b0);
        step(1, 0, 0, 0, 11'h000, 5'h00);
        check("R2 wrap", 13'h0000, 1'b0);
        step(0, 1, 0, 0, 11'h7FF, 5'h18);
        step(0, 0, 0, 0, 11'h000, 5'h00);
        step(0, 1, 0, 0, 11'h040, 5'h07);
        check("R3 low latch bits ignored", 13'h0040, 1'b1);
        step(1, 0, 0, 0, 11'h000, 5'h00);
        step(0, 0, 1, 0, 11'h000, 5'h00);
        check("R4 pushed address wraps", 13'h0000, 1'b1);

        // R7: nine pushes into eight slots
        do_reset();
        for (int i = 0; i < 9; i++) begin
            step(0, 1, 0, 0, 11'h100 + 11'(i), 5'h00);
            step(0, 0, 0, 0, 11'h000, 5'h00);
        end
        for (int k = 1; k <= 8; k++) begin
            step(0, 0, 1, 0, 11'h000, 5'h00);
            check($sformatf("R7 pop %0d", k), 13'h0100 + 13'(9 - k), 1'b1);
            step(0, 0, 0, 0, 11'h000, 5'h00);
        end
        step(0, 0, 1, 0, 11'h000, 5'h00);
        check("R7 ninth pop sees overwritten slot", 13'h0108, 1'b1);

        // R9: vector load neither pushes nor pops, and wins inside a dead cycle
        do_reset();
        step(0, 1, 0, 0, 11'h200, 5'h00);
        step(0, 0, 0, 0, 11'h000, 5'h00);
        step(0, 0, 1, 1, 11'h000, 5'h00);
        check("R9 vector load", 13'h0004, 1'b1);
        step(1, 0, 0, 0, 11'h000, 5'h00);
        check("R5 step in dead cycle", 13'h0005, 1'b0);
        step(0, 0, 1, 0, 11'h000, 5'h00);
        check("R9 stack untouched by vector", 13'h0001, 1'b1);
        step(0, 0, 0, 1, 11'h000, 5'h00);
        check("R9 vector inside dead cycle", 13'h0004, 1'b1);
        step(0, 0, 1, 0, 11'h000, 5'h00);
        check("R5 return ignored in dead cycle", 13'h0004, 1'b0);
        step(0, 0, 0, 0, 11'h000, 5'h00);
        check("R2 hold without strobe", 13'h0004, 1'b0);

        finish_run();
    end
endmodule